// File: doc/BRIEF.md
# Boot-Window Command Decoder

This block sits behind the host write port of a flash memory interface. It watches every host write. A write that lands in one of two small address windows is read as a boot command. Any other write is passed, one cycle later, to the register file that sits beside it. Three boot commands are understood:

- a warm reset request;
- a two-write page load, where an arming word is followed by a go word and the block issues a load request for one full page into data buffer 0;
- an identification read, which fills the first three boot-buffer words with identity bytes.

After a page load is issued, the block hands the register file a new page address: the old one stepped forward by one page (four sectors) and wrapped inside 8 bits. The sector number for the load is formed from the block and page address registers. A density mask is folded into the block number when the block register's top bit is set.

The load request is a single-cycle pulse. The block then stays busy until the array side returns a load-done pulse. While it is busy, a new arming word is dropped. All outputs are registered, so each takes effect on the clock edge after the write that caused it.

Top module: `boot_cmd_decoder`

## Requirements
- R1: A write is a boot command only when its word address lies in 0x0000..0x01FF or 0x8000..0x800F. Any other write appears on reg_wr_en/reg_wr_addr/reg_wr_data one cycle later and has no command effect. A boot command never drives reg_wr_en.
- R2: A window write of 0x00F0, when not armed, gives a one-cycle reset_req pulse in the next cycle.
- R3: A window write of 0x00E0, when neither armed nor busy, arms the block. The next window write of 0x0000 gives a one-cycle load_req pulse in the next cycle, with load_count = 4.
- R4: load_sector = ((page[7:2] + N*64) << 2) + page[1:0]. N is blk_addr[11:0], ORed with dens_mask when blk_addr[15] = 1. The page and block values are the ones present at the go write.
- R5: page_upd_en pulses together with load_req. page_upd_val = (page + 4) & 0xFF, zero-extended to 16 bits.
- R6: While armed, a window write of any value other than 0x0000 disarms the block and has no other effect. There is no reset, no load, no unknown flag and no ID write.
- R7: A window write of 0x0090, when not armed, gives three id_wr_en pulses in the three following cycles. The indices are 0, 1 and 2. The data words are {0x00, man_id[7:0]}, {0x00, dev_id[7:0]} and {0x00, wp_status[7:0]}.
- R8: When not armed, any window write value other than 0x00F0, 0x00E0 or 0x0090 gives a one-cycle unknown_cmd pulse and nothing else.
- R9: rst_n low clears the armed state. A write outside the windows leaves the armed state unchanged.
- R10: load_busy rises with load_req and stays high until a cycle in which load_done is high. While it is high, 0x00E0 does not arm and raises no flag.
- R11: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host word address |
| wr_data | input | 16 | Host write data |
| blk_addr | input | 16 | Current block address register |
| page_addr | input | 16 | Current page/sector address register |
| dens_mask | input | 16 | Density mask ORed into the block number |
| man_id | input | 16 | Manufacturer identity |
| dev_id | input | 16 | Device identity |
| wp_status | input | 16 | Write-protect status |
| load_done | input | 1 | Array side finished the page load |
| reset_req | output | 1 | Warm reset request pulse |
| reg_wr_en | output | 1 | Forwarded register write strobe |
| reg_wr_addr | output | 16 | Forwarded register write address |
| reg_wr_data | output | 16 | Forwarded register write data |
| unknown_cmd | output | 1 | Unrecognised boot command pulse |
| load_req | output | 1 | Page load request pulse |
| load_sector | output | 24 | First sector of the page load |
| load_count | output | 3 | Sectors in the page load |
| load_busy | output | 1 | Load outstanding |
| page_upd_en | output | 1 | Page register update strobe |
| page_upd_val | output | 16 | New page register value |
| id_wr_en | output | 1 | Boot-buffer ID word write strobe |
| id_wr_idx | output | 2 | Boot-buffer word index |
| id_wr_data | output | 16 | Boot-buffer word data |

## Verification
The bench goes after the window edges: 0x01FF and 0x800F are inside, 0x0200 and 0x8010 are outside. A decoder with an off-by-one edge would forward a boot command as a register write, or decode a register write as a command. It sets the page to 0xFE before a load, so a page step that did not wrap in 8 bits would produce 0x102. It sets the block's top bit, so a design that dropped the density mask would produce the wrong sector.

The bench also covers the armed state. It sends 0x00F0 while armed, which must be swallowed and not turned into a reset. It sends 0x00E0 while a load is outstanding, which must not arm; a design that armed anyway would issue a second load. It applies reset while armed, so a stale armed flag would turn a later 0x0000 into a load instead of an unknown command. Random traffic then mixes all commands with load-done pulses against a cycle model.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;
  localparam int WORD_W     = 16;
  localparam int PG_FIELD_W = 8;
  localparam int SECT_SHIFT = 2;
  localparam int SPP        = 1 << SECT_SHIFT;
  localparam int CNT_W      = SECT_SHIFT + 1;
  localparam int SECTOR_W   = WORD_W + PG_FIELD_W;

  localparam logic [WORD_W-1:0] CMD_WARM_RESET = 16'h00F0;
  localparam logic [WORD_W-1:0] CMD_LOAD_ARM   = 16'h00E0;
  localparam logic [WORD_W-1:0] CMD_LOAD_GO    = 16'h0000;
  localparam logic [WORD_W-1:0] CMD_READ_ID    = 16'h0090;

  localparam logic [PG_FIELD_W-1:0] PAGE_STEP = PG_FIELD_W'(SPP);

  // Block number with the density mask folded in.
  function automatic logic [WORD_W-1:0] block_number(
    input logic [WORD_W-1:0] blk,
    input logic [WORD_W-1:0] field_mask,
    input logic [WORD_W-1:0] dmask
  );
    return (blk & field_mask) | (blk[WORD_W-1] ? dmask : '0);
  endfunction

  // First sector of the page addressed by the block and page registers.
  function automatic logic [SECTOR_W-1:0] load_sector_of(
    input logic [WORD_W-1:0] blk,
    input logic [WORD_W-1:0] page,
    input logic [WORD_W-1:0] field_mask,
    input logic [WORD_W-1:0] dmask
  );
    logic [SECTOR_W-1:0] pg_total;
    pg_total = SECTOR_W'(page[PG_FIELD_W-1:SECT_SHIFT])
             + (SECTOR_W'(block_number(blk, field_mask, dmask)) << (PG_FIELD_W - SECT_SHIFT));
    return (pg_total << SECT_SHIFT) + SECTOR_W'(page[SECT_SHIFT-1:0]);
  endfunction

  // Page register after a page load: one page on, wrapped in the page field.
  function automatic logic [WORD_W-1:0] next_page(input logic [WORD_W-1:0] page);
    logic [PG_FIELD_W-1:0] stepped;
    stepped = page[PG_FIELD_W-1:0] + PAGE_STEP;
    return WORD_W'(stepped);
  endfunction
endpackage

// File: rtl/bcd_window_decode.sv
module bcd_window_decode #(
  parameter int ADDR_W    = 16,
  parameter int WIN0_BASE = 'h0000,
  parameter int WIN0_LEN  = 'h0200,
  parameter int WIN1_BASE = 'h8000,
  parameter int WIN1_LEN  = 'h0010
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              win_hit,
  output logic              reg_hit
);
  localparam int NWIN = 2;
  localparam int EXT_W = ADDR_W + 1;
  localparam logic [EXT_W-1:0] LO [NWIN] = '{EXT_W'(WIN0_BASE), EXT_W'(WIN1_BASE)};
  localparam logic [EXT_W-1:0] HI [NWIN] = '{EXT_W'(WIN0_BASE + WIN0_LEN),
                                              EXT_W'(WIN1_BASE + WIN1_LEN)};

  logic [NWIN-1:0] in_win;
  logic [EXT_W-1:0] addr_ext;

  assign addr_ext = EXT_W'(wr_addr);

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    assign in_win[gi] = (addr_ext >= LO[gi]) && (addr_ext < HI[gi]);
  end

  assign win_hit = wr_en && (|in_win);
  assign reg_hit = wr_en && !(|in_win);
endmodule

// File: rtl/bcd_load_ctrl.sv
module bcd_load_ctrl
  import boot_cmd_pkg::*;
#(
  parameter int BLK_FIELD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_arm_req,
  input  logic                ev_fire,
  input  logic                ev_cancel,
  input  logic                load_done,
  input  logic [WORD_W-1:0]   blk_addr,
  input  logic [WORD_W-1:0]   page_addr,
  input  logic [WORD_W-1:0]   dens_mask,
  output logic                armed,
  output logic                load_req,
  output logic [SECTOR_W-1:0] load_sector,
  output logic [CNT_W-1:0]    load_count,
  output logic                load_busy,
  output logic                page_upd_en,
  output logic [WORD_W-1:0]   page_upd_val
);
  localparam logic [WORD_W-1:0] FIELD_MASK = WORD_W'((1 << BLK_FIELD_W) - 1);

  logic arm_ok;
  assign arm_ok = ev_arm_req && !load_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (arm_ok) begin
      armed <= 1'b1;
    end else if (ev_fire || ev_cancel) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_busy <= 1'b0;
    end else if (ev_fire) begin
      load_busy <= 1'b1;
    end else if (load_done) begin
      load_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_req     <= 1'b0;
      load_sector  <= '0;
      load_count   <= '0;
      page_upd_en  <= 1'b0;
      page_upd_val <= '0;
    end else begin
      load_req    <= ev_fire;
      page_upd_en <= ev_fire;
      if (ev_fire) begin
        load_sector  <= load_sector_of(blk_addr, page_addr, FIELD_MASK, dens_mask);
        load_count   <= CNT_W'(SPP);
        page_upd_val <= next_page(page_addr);
      end else begin
        load_sector  <= '0;
        load_count   <= '0;
        page_upd_val <= '0;
      end
    end
  end
endmodule

// File: rtl/bcd_id_writer.sv
module bcd_id_writer
  import boot_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] man_id,
  input  logic [WORD_W-1:0] dev_id,
  input  logic [WORD_W-1:0] wp_status,
  output logic              id_wr_en,
  output logic [1:0]        id_wr_idx,
  output logic [WORD_W-1:0] id_wr_data
);
  logic [1:0] step;
  logic [7:0] dev_l;
  logic [7:0] wp_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step       <= 2'd0;
      dev_l      <= '0;
      wp_l       <= '0;
      id_wr_en   <= 1'b0;
      id_wr_idx  <= '0;
      id_wr_data <= '0;
    end else if (start) begin
      step       <= 2'd1;
      dev_l      <= dev_id[7:0];
      wp_l       <= wp_status[7:0];
      id_wr_en   <= 1'b1;
      id_wr_idx  <= 2'd0;
      id_wr_data <= {8'h00, man_id[7:0]};
    end else begin
      case (step)
        2'd1: begin
          step       <= 2'd2;
          id_wr_en   <= 1'b1;
          id_wr_idx  <= 2'd1;
          id_wr_data <= {8'h00, dev_l};
        end
        2'd2: begin
          step       <= 2'd0;
          id_wr_en   <= 1'b1;
          id_wr_idx  <= 2'd2;
          id_wr_data <= {8'h00, wp_l};
        end
        default: begin
          step       <= 2'd0;
          id_wr_en   <= 1'b0;
          id_wr_idx  <= '0;
          id_wr_data <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/boot_cmd_decoder.sv
module boot_cmd_decoder
  import boot_cmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WIN0_BASE   = 'h0000,
  parameter int WIN0_LEN    = 'h0200,
  parameter int WIN1_BASE   = 'h8000,
  parameter int WIN1_LEN    = 'h0010,
  parameter int BLK_FIELD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [WORD_W-1:0]   blk_addr,
  input  logic [WORD_W-1:0]   page_addr,
  input  logic [WORD_W-1:0]   dens_mask,
  input  logic [WORD_W-1:0]   man_id,
  input  logic [WORD_W-1:0]   dev_id,
  input  logic [WORD_W-1:0]   wp_status,
  input  logic                load_done,
  output logic                reset_req,
  output logic                reg_wr_en,
  output logic [ADDR_W-1:0]   reg_wr_addr,
  output logic [WORD_W-1:0]   reg_wr_data,
  output logic                unknown_cmd,
  output logic                load_req,
  output logic [SECTOR_W-1:0] load_sector,
  output logic [CNT_W-1:0]    load_count,
  output logic                load_busy,
  output logic                page_upd_en,
  output logic [WORD_W-1:0]   page_upd_val,
  output logic                id_wr_en,
  output logic [1:0]          id_wr_idx,
  output logic [WORD_W-1:0]   id_wr_data
);
  // Named internal events, visible to the bound checker.
  logic win_hit, reg_hit, armed;
  logic hit_idle, hit_armed;
  logic ev_reset, ev_arm_req, ev_id, ev_unknown, ev_fire, ev_cancel;

  bcd_window_decode #(
    .ADDR_W(ADDR_W), .WIN0_BASE(WIN0_BASE), .WIN0_LEN(WIN0_LEN),
    .WIN1_BASE(WIN1_BASE), .WIN1_LEN(WIN1_LEN)
  ) u_win (
    .wr_en(wr_en), .wr_addr(wr_addr), .win_hit(win_hit), .reg_hit(reg_hit)
  );

  assign hit_idle   = win_hit && !armed;
  assign hit_armed  = win_hit && armed;
  assign ev_reset   = hit_idle && (wr_data == CMD_WARM_RESET);
  assign ev_arm_req = hit_idle && (wr_data == CMD_LOAD_ARM);
  assign ev_id      = hit_idle && (wr_data == CMD_READ_ID);
  assign ev_unknown = hit_idle && !ev_reset && !ev_arm_req && !ev_id;
  assign ev_fire    = hit_armed && (wr_data == CMD_LOAD_GO);
  assign ev_cancel  = hit_armed && (wr_data != CMD_LOAD_GO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_req   <= 1'b0;
      unknown_cmd <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else begin
      reset_req   <= ev_reset;
      unknown_cmd <= ev_unknown;
      reg_wr_en   <= reg_hit;
      reg_wr_addr <= reg_hit ? wr_addr : '0;
      reg_wr_data <= reg_hit ? wr_data : '0;
    end
  end

  bcd_load_ctrl #(.BLK_FIELD_W(BLK_FIELD_W)) u_load (
    .clk(clk), .rst_n(rst_n),
    .ev_arm_req(ev_arm_req), .ev_fire(ev_fire), .ev_cancel(ev_cancel),
    .load_done(load_done), .blk_addr(blk_addr), .page_addr(page_addr),
    .dens_mask(dens_mask), .armed(armed), .load_req(load_req),
    .load_sector(load_sector), .load_count(load_count), .load_busy(load_busy),
    .page_upd_en(page_upd_en), .page_upd_val(page_upd_val)
  );

  bcd_id_writer u_id (
    .clk(clk), .rst_n(rst_n), .start(ev_id),
    .man_id(man_id), .dev_id(dev_id), .wp_status(wp_status),
    .id_wr_en(id_wr_en), .id_wr_idx(id_wr_idx), .id_wr_data(id_wr_data)
  );
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker
  import boot_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              win_hit,
  input logic              armed,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] page_addr,
  input logic              reset_req,
  input logic              load_req,
  input logic              load_busy,
  input logic              unknown_cmd,
  input logic              reg_wr_en,
  input logic              page_upd_en,
  input logic [WORD_W-1:0] page_upd_val,
  input logic              id_wr_en,
  input logic [1:0]        id_wr_idx
);
  // R1
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_req, load_req, unknown_cmd, reg_wr_en}));

  // R2
  reset_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(win_hit) && !$past(armed) && ($past(wr_data) == CMD_WARM_RESET));

  // R3
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> $past(win_hit) && $past(armed) && ($past(wr_data) == CMD_LOAD_GO));

  // R5
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> page_upd_en
      && (page_upd_val == {8'h00, 8'($past(page_addr[7:0]) + PAGE_STEP)}));

  // R6
  disarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(win_hit));

  // R7
  id_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr_en && id_wr_idx != 2'd0) |-> $past(id_wr_en) && ($past(id_wr_idx) == id_wr_idx - 2'd1));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_busy) |-> load_req);

  // R10
  no_arm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> !$past(load_busy));
endmodule

bind boot_cmd_decoder bcd_checker u_bcd_chk (
  .clk(clk), .rst_n(rst_n), .win_hit(win_hit), .armed(armed),
  .wr_data(wr_data), .page_addr(page_addr), .reset_req(reset_req),
  .load_req(load_req), .load_busy(load_busy), .unknown_cmd(unknown_cmd),
  .reg_wr_en(reg_wr_en), .page_upd_en(page_upd_en), .page_upd_val(page_upd_val),
  .id_wr_en(id_wr_en), .id_wr_idx(id_wr_idx)
);

// File: tb/test_boot_cmd_decoder.sv
module test_boot_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic [15:0] blk_addr = '0, page_addr = '0, dens_mask = '0;
  logic [15:0] man_id = 16'h12EC, dev_id = 16'h3440, wp_status = 16'h0002;
  logic        load_done = 1'b0;
  logic        reset_req, reg_wr_en, unknown_cmd, load_req, load_busy;
  logic        page_upd_en, id_wr_en;
  logic [15:0] reg_wr_addr, reg_wr_data, page_upd_val, id_wr_data;
  logic [23:0] load_sector;
  logic [2:0]  load_count;
  logic [1:0]  id_wr_idx;

  boot_cmd_decoder i_boot_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_addr(blk_addr), .page_addr(page_addr), .dens_mask(dens_mask),
    .man_id(man_id), .dev_id(dev_id), .wp_status(wp_status), .load_done(load_done),
    .reset_req(reset_req), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .unknown_cmd(unknown_cmd), .load_req(load_req),
    .load_sector(load_sector), .load_count(load_count), .load_busy(load_busy),
    .page_upd_en(page_upd_en), .page_upd_val(page_upd_val), .id_wr_en(id_wr_en),
    .id_wr_idx(id_wr_idx), .id_wr_data(id_wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Bench model state
  bit m_armed = 0, m_busy = 0;
  int m_idstep = 0;
  logic [7:0] m_dev = '0, m_wp = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return (a <= 16'h01FF) || (a >= 16'h8000 && a <= 16'h800F);
  endfunction

  function automatic logic [23:0] exp_sector(input logic [15:0] b, input logic [15:0] p, input logic [15:0] m);
    logic [15:0] n;
    n = {4'h0, b[11:0]} | (b[15] ? m : 16'h0);
    return {n, p[7:0]};
  endfunction

  // One clock cycle of stimulus with full output comparison at the next negedge.
  task automatic step(input logic we, input logic [15:0] a, input logic [15:0] d, input logic dn);
    bit hit, hidle, e_rst, e_fire, e_unk, e_reg, e_arm, e_id, id_en;
    logic [1:0] id_idx;
    logic [15:0] id_dat, e_pg;
    logic [23:0] e_sec;
    hit    = we && in_win(a);
    hidle  = hit && !m_armed;
    e_reg  = we && !in_win(a);
    e_rst  = hidle && d == 16'h00F0;
    e_id   = hidle && d == 16'h0090;
    e_arm  = hidle && d == 16'h00E0 && !m_busy;
    e_unk  = hidle && d != 16'h00F0 && d != 16'h00E0 && d != 16'h0090;
    e_fire = hit && m_armed && d == 16'h0000;
    e_sec  = exp_sector(blk_addr, page_addr, dens_mask);
    e_pg   = {8'h00, page_addr[7:0] + 8'd4};
    id_en = 0; id_idx = 0; id_dat = 0;
    if (e_id) begin
      id_en = 1; id_idx = 0; id_dat = {8'h00, man_id[7:0]};
      m_dev = dev_id[7:0]; m_wp = wp_status[7:0]; m_idstep = 1;
    end else if (m_idstep == 1) begin
      id_en = 1; id_idx = 1; id_dat = {8'h00, m_dev}; m_idstep = 2;
    end else if (m_idstep == 2) begin
      id_en = 1; id_idx = 2; id_dat = {8'h00, m_wp}; m_idstep = 0;
    end
    wr_en = we; wr_addr = a; wr_data = d; load_done = dn;
    @(negedge clk);
    wr_en = 0; load_done = 0;
    chk(reg_wr_en == e_reg, "R1 reg_wr_en", 32'(reg_wr_en), 32'(e_reg));
    if (e_reg) begin
      chk(reg_wr_addr == a && reg_wr_data == d, "R1 forwarded write",
          {reg_wr_addr, reg_wr_data}, {a, d});
    end
    chk(reset_req == e_rst, "R2 reset_req", 32'(reset_req), 32'(e_rst));
    chk(load_req == e_fire, "R3 load_req", 32'(load_req), 32'(e_fire));
    if (e_fire) begin
      chk(load_count == 3'd4, "R3 load_count", 32'(load_count), 32'd4);
      chk(load_sector == e_sec, "R4 load_sector", 32'(load_sector), 32'(e_sec));
    end
    chk(page_upd_en == e_fire, "R5 page_upd_en", 32'(page_upd_en), 32'(e_fire));
    if (e_fire) chk(page_upd_val == e_pg, "R5 page_upd_val", 32'(page_upd_val), 32'(e_pg));
    chk(unknown_cmd == e_unk, "R8 unknown_cmd", 32'(unknown_cmd), 32'(e_unk));
    chk(id_wr_en == id_en, "R7 id_wr_en", 32'(id_wr_en), 32'(id_en));
    if (id_en) chk(id_wr_idx == id_idx && id_wr_data == id_dat, "R7 id word",
                   {14'h0, id_wr_idx, id_wr_data}, {14'h0, id_idx, id_dat});
    // model update
    if (e_fire) m_busy = 1; else if (dn) m_busy = 0;
    if (e_arm) m_armed = 1; else if (hit && m_armed) m_armed = 0;
    chk(load_busy == m_busy, "R10 load_busy", 32'(load_busy), 32'(m_busy));
    if (e_fire) page_addr = page_upd_val;
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; load_done = 0;
    repeat (2) @(negedge clk);
    // R11
    chk({reset_req, reg_wr_en, unknown_cmd, load_req, load_busy, page_upd_en, id_wr_en} == 7'h0
        && load_sector == 0 && page_upd_val == 0 && id_wr_data == 0, "R11 reset state",
        {25'h0, reset_req, reg_wr_en, unknown_cmd, load_req, load_busy, page_upd_en, id_wr_en}, 32'h0);
    rst_n = 1;
    m_armed = 0; m_busy = 0; m_idstep = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R1 window edges
    step(1, 16'h0200, 16'h00F0, 0);
    step(1, 16'h8010, 16'h00F0, 0);
    step(1, 16'h01FF, 16'h00F0, 0);
    step(1, 16'h800F, 16'h0055, 0);
    // R2 reset
    step(1, 16'h0000, 16'h00F0, 0);
    // R3/R4/R5: page wrap and density mask
    blk_addr = 16'h8123; dens_mask = 16'h0400; page_addr = 16'h00FE;
    step(1, 16'h0010, 16'h00E0, 0);
    step(1, 16'h8003, 16'h0000, 0);
    chk(page_addr == 16'h0002, "R5 wrap", 32'(page_addr), 32'h2);
    // R10: arm while busy is dropped, the go word is then unknown
    step(1, 16'h0000, 16'h00E0, 0);
    step(1, 16'h0000, 16'h0000, 0);
    chk(load_req == 0, "R10 no load while busy", 32'(load_req), 32'h0);
    step(0, 16'h0, 16'h0, 1);
    // R6: cancel by a reset value while armed
    step(1, 16'h0000, 16'h00E0, 0);
    step(1, 16'h0001, 16'h00F0, 0);
    chk(reset_req == 0, "R6 swallowed command", 32'(reset_req), 32'h0);
    step(1, 16'h0001, 16'h0000, 0);
    chk(load_req == 0 && unknown_cmd == 1, "R6 disarmed", {31'h0, load_req}, 32'h0);
    // R9: outside write keeps armed, reset clears it
    step(1, 16'h0000, 16'h00E0, 0);
    step(1, 16'h4000, 16'h0000, 0);
    step(1, 16'h0000, 16'h0000, 0);
    chk(load_req == 1, "R9 armed kept across reg write", 32'(load_req), 32'h1);
    step(0, 16'h0, 16'h0, 1);
    step(1, 16'h0000, 16'h00E0, 0);
    do_reset();
    step(1, 16'h0000, 16'h0000, 0);
    chk(load_req == 0, "R9 reset disarms", 32'(load_req), 32'h0);
    // R7 identification
    step(1, 16'h0100, 16'h0090, 0);
    step(0, 16'h0, 16'h0, 0);
    step(0, 16'h0, 16'h0, 0);
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, d;
      int sel;
      sel = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: a = 16'($urandom_range(0, 16'h01FF));
        1: a = 16'h8000 + 16'($urandom_range(0, 15));
        2: a = 16'($urandom_range(16'h0200, 16'h7FFF));
        default: a = 16'($urandom_range(16'h8010, 16'hFFFF));
      endcase
      case (sel)
        0, 1: d = 16'h00E0;
        2, 3: d = 16'h0000;
        4: d = 16'h00F0;
        5: d = 16'h0090;
        default: d = 16'($urandom);
      endcase
      if ($urandom_range(0, 7) == 0) begin
        blk_addr = 16'($urandom); page_addr = 16'($urandom); dens_mask = 16'($urandom);
        man_id = 16'($urandom); dev_id = 16'($urandom); wp_status = 16'($urandom);
      end
      step($urandom_range(0, 4) != 0, a, d, $urandom_range(0, 3) == 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule